// File: doc/BRIEF.md
# Framed Receive Block Buffer

This block buffers received bytes between a serial frame receiver and a host. The receiver writes one byte per write strobe and marks where a frame starts and where it ends. The byte written with the end marker is the frame's status byte, so it lands after the data. Bytes first enter a hidden 32-entry staging queue. A transfer engine then moves them, one per cycle, into a 32-byte pool that the host can read.

A block closes when the pool holds 32 bytes or when a frame's status byte has been moved. The block then records the block length and raises one of two flags. The pool-full flag marks an intermediate block and the message-end flag marks the last block of a frame. The host reads the pool in arrival order and releases it with an acknowledge strobe, and only then does the next block move in. If the staging queue is full when a frame begins, the whole frame is thrown away and an overflow flag is raised. A transparent mode ignores frame markers and delivers plain 32-byte blocks. Reading the status register clears the flags, and a receiver reset command clears everything.

Top module: `rxblk_fifo`

## Requirements
- R1: In framed mode, a frame whose data plus status byte total at most 32 entries is delivered as one block. That block sets the message-end flag and not the pool-full flag. `blk_count` then shows the number of entries including the status byte, with 32 shown as 0.
- R2: In framed mode, a longer frame is split. Each block of 32 entries that does not contain the status byte sets the pool-full flag only, with `blk_count` = 0. The remaining part sets the message-end flag.
- R3: `rd_data` shows the pool byte at the read position. Each `rd_en` pulse advances the position by one. Bytes come out in arrival order, and the status byte is last in a message-end block.
- R4: Once a block is loaded, no further byte enters the pool and `blk_count` holds until `rx_ack` is pulsed.
- R5: In framed mode, a write marked as frame start that finds the staging queue holding 32 entries is discarded and sets the overflow flag. Every further byte of that frame, up to and including its end-marked byte, is also discarded. A later frame start is accepted normally.
- R6: In transparent mode, the start and end markers are ignored. Every 32 bytes moved set the pool-full flag, and the message-end flag is never set.
- R7: In transparent mode, a write that finds the staging queue full is lost and sets the overflow flag.
- R8: `isr_flags` bit 0 is pool full, bit 1 is message end and bit 2 is overflow. A one-cycle `isr_rd` clears all three. A flag whose set event falls in the same cycle as `isr_rd` stays set.
- R9: `rx_reset` clears all flags and `blk_count`, and empties both the staging queue and the pool.
- R10: `irq` is high exactly when some flag is set whose bit in `int_mask` (same bit order as `isr_flags`) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_transp | input | 1 | 1 selects transparent mode, 0 framed mode |
| wr_valid | input | 1 | Receiver byte write strobe |
| wr_sof | input | 1 | Written byte begins a frame |
| wr_eof | input | 1 | Written byte is the frame's status byte |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Advance the pool read position |
| rd_data | output | 8 | Pool byte at the read position |
| rx_ack | input | 1 | Host releases the loaded block |
| isr_rd | input | 1 | Status register read strobe |
| rx_reset | input | 1 | Receiver reset command |
| int_mask | input | 3 | Per-flag interrupt mask, 1 masks |
| isr_flags | output | 3 | Pool full, message end, overflow flags |
| blk_count | output | 5 | Entry count of the last loaded block |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a short frame, a frame of 41 entries and a frame of exactly 32 entries. Together these separate the message-end-only case, the split into a pool-full block plus a tail, and the count wrap from 32 to 0. A run that keeps the pool unreleased fills the staging queue and then sends a frame start. Reading out the following blocks shows whether that frame and every one of its later bytes were dropped, as opposed to the start byte alone. Transparent traffic with stray markers tells mode-dependent block closing apart from framed closing. Pulses of the status read and reset strobes, one of them in the same cycle as an overflow event, check clear priority and show that stale bytes are gone.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_PFULL = 0;
  localparam int unsigned FLG_MEND  = 1;
  localparam int unsigned FLG_OVF   = 2;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  last;
    byte_t data;
  } entry_t;
endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/rxq_stage.sv
module rxq_stage
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   transp,
  input  logic   wr_valid,
  input  logic   wr_sof,
  input  logic   wr_eof,
  input  byte_t  wr_data,
  input  logic   pop,
  output entry_t head,
  output logic   empty,
  output logic   full,
  output logic   ovf_ev
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] PONE  = 1;
  localparam logic [AW:0] DFULL = (AW+1)'(DEPTH);

  entry_t      mem [DEPTH];
  logic [AW:0] wp_q, rp_q, wp_d, rp_d, fill;
  logic        drop_q, drop_d;
  logic        push;

  assign fill  = wp_q - rp_q;
  assign full  = (fill == DFULL);
  assign empty = (wp_q == rp_q);
  assign head  = mem[rp_q[AW-1:0]];

  // admission: decides store, discard or overflow for each write
  always_comb begin
    push   = 1'b0;
    ovf_ev = 1'b0;
    drop_d = drop_q;
    if (wr_valid) begin
      if (transp) begin
        drop_d = 1'b0;
        if (full) ovf_ev = 1'b1;
        else      push   = 1'b1;
      end else if (wr_sof) begin
        if (full) begin
          ovf_ev = 1'b1;
          drop_d = !wr_eof;
        end else begin
          push   = 1'b1;
          drop_d = 1'b0;
        end
      end else if (drop_q) begin
        if (wr_eof) drop_d = 1'b0;
      end else if (full) begin
        ovf_ev = 1'b1;
      end else begin
        push = 1'b1;
      end
    end
  end

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (clr) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (push) wp_d = wp_q + PONE;
      if (pop)  rp_d = rp_q + PONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      drop_q <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      drop_q <= clr ? 1'b0 : drop_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) begin
      mem[wp_q[AW-1:0]] <= '{last: wr_eof && !transp, data: wr_data};
    end
  end
endmodule

// File: rtl/rxq_pool.sv
module rxq_pool
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     in_avail,
  input  entry_t                   in_entry,
  input  logic                     rd_en,
  input  logic                     ack,
  output logic                     take,
  output logic                     blk_done,
  output logic                     blk_last,
  output logic                     loaded,
  output byte_t                    rd_data,
  output logic [$clog2(DEPTH)-1:0] rbc
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0]   WONE  = 1;
  localparam logic [AW-1:0] RONE  = 1;
  localparam logic [AW:0]   WLAST = (AW+1)'(DEPTH - 1);

  byte_t         mem [DEPTH];
  logic [AW:0]   wcnt_q, wcnt_d;
  logic [AW-1:0] rptr_q, rptr_d, rbc_q, rbc_d;
  logic          loaded_q, loaded_d;

  assign take     = in_avail && !loaded_q;
  assign blk_last = take && in_entry.last;
  assign blk_done = take && (in_entry.last || (wcnt_q == WLAST));
  assign loaded   = loaded_q;
  assign rd_data  = mem[rptr_q];
  assign rbc      = rbc_q;

  always_comb begin
    wcnt_d   = wcnt_q;
    rptr_d   = rptr_q;
    rbc_d    = rbc_q;
    loaded_d = loaded_q;
    if (clr) begin
      wcnt_d   = '0;
      rptr_d   = '0;
      rbc_d    = '0;
      loaded_d = 1'b0;
    end else if (loaded_q) begin
      if (ack) begin
        wcnt_d   = '0;
        rptr_d   = '0;
        loaded_d = 1'b0;
      end else if (rd_en) begin
        rptr_d = rptr_q + RONE;
      end
    end else if (take) begin
      wcnt_d = wcnt_q + WONE;
      if (blk_done) begin
        loaded_d = 1'b1;
        rbc_d    = wcnt_q[AW-1:0] + RONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q   <= '0;
      rptr_q   <= '0;
      rbc_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      wcnt_q   <= wcnt_d;
      rptr_q   <= rptr_d;
      rbc_q    <= rbc_d;
      loaded_q <= loaded_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !clr) mem[wcnt_q[AW-1:0]] <= in_entry.data;
  end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 rd_clr,
  input  logic [NUM_FLAGS-1:0] set,
  output logic [NUM_FLAGS-1:0] flags
);
  logic [NUM_FLAGS-1:0] flags_q, flags_d;

  // priority: command reset, then new events, then status read
  always_comb begin
    if (clr)         flags_d = '0;
    else if (rd_clr) flags_d = set;
    else             flags_d = flags_q | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/rxblk_fifo.sv
module rxblk_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned STAGE_DEPTH = 32,
  parameter int unsigned POOL_DEPTH  = 32,
  localparam int unsigned CNT_W      = $clog2(POOL_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_transp,
  input  logic                 wr_valid,
  input  logic                 wr_sof,
  input  logic                 wr_eof,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic                 rd_en,
  output logic [BYTE_W-1:0]    rd_data,
  input  logic                 rx_ack,
  input  logic                 isr_rd,
  input  logic                 rx_reset,
  input  logic [NUM_FLAGS-1:0] int_mask,
  output logic [NUM_FLAGS-1:0] isr_flags,
  output logic [CNT_W-1:0]     blk_count,
  output logic                 irq
);
  logic                 rst_s;
  entry_t               head;
  logic                 stage_empty, stage_full, ovf_ev;
  logic                 take, blk_done, blk_last, pool_loaded;
  logic [NUM_FLAGS-1:0] flag_set;

  rxq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s)
  );

  rxq_stage #(.DEPTH(STAGE_DEPTH)) u_stage (
    .clk      (clk),
    .rst_n    (rst_s),
    .clr      (rx_reset),
    .transp   (mode_transp),
    .wr_valid (wr_valid),
    .wr_sof   (wr_sof),
    .wr_eof   (wr_eof),
    .wr_data  (wr_data),
    .pop      (take),
    .head     (head),
    .empty    (stage_empty),
    .full     (stage_full),
    .ovf_ev   (ovf_ev)
  );

  rxq_pool #(.DEPTH(POOL_DEPTH)) u_pool (
    .clk      (clk),
    .rst_n    (rst_s),
    .clr      (rx_reset),
    .in_avail (!stage_empty),
    .in_entry (head),
    .rd_en    (rd_en),
    .ack      (rx_ack),
    .take     (take),
    .blk_done (blk_done),
    .blk_last (blk_last),
    .loaded   (pool_loaded),
    .rd_data  (rd_data),
    .rbc      (blk_count)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_PFULL] = blk_done && !blk_last;
    flag_set[FLG_MEND]  = blk_done && blk_last && !mode_transp;
    flag_set[FLG_OVF]   = ovf_ev;
  end

  rxq_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr    (rx_reset),
    .rd_clr (isr_rd),
    .set    (flag_set),
    .flags  (isr_flags)
  );

  assign irq = |(isr_flags & ~int_mask);
endmodule

// File: rtl/rxblk_fifo_chk.sv
module rxblk_fifo_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_reset,
  input logic             isr_rd,
  input logic             rx_ack,
  input logic             mode_transp,
  input logic             wr_valid,
  input logic             wr_sof,
  input logic [2:0]       flag_set,
  input logic [2:0]       isr_flags,
  input logic [CNT_W-1:0] blk_count,
  input logic             pool_loaded,
  input logic             stage_empty,
  input logic             stage_full,
  input logic             blk_done
);
  // R9
  rres_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (isr_flags == 3'b000 && blk_count == '0 && !pool_loaded && stage_empty));

  // R8
  status_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !rx_reset && flag_set == 3'b000) |=> (isr_flags == 3'b000));

  // R8
  read_keeps_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !rx_reset && flag_set[2]) |=> isr_flags[2]);

  // R1
  single_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !($rose(isr_flags[0]) && $rose(isr_flags[1])));

  // R6
  transp_no_mend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_transp |=> !$rose(isr_flags[1]));

  // R4
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_loaded && !rx_ack && !rx_reset) |=> (pool_loaded && $stable(blk_count)));

  // R5
  sof_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sof && !mode_transp && stage_full && !rx_reset) |=> isr_flags[2]);
endmodule

bind rxblk_fifo rxblk_fifo_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_s),
  .rx_reset    (rx_reset),
  .isr_rd      (isr_rd),
  .rx_ack      (rx_ack),
  .mode_transp (mode_transp),
  .wr_valid    (wr_valid),
  .wr_sof      (wr_sof),
  .flag_set    (flag_set),
  .isr_flags   (isr_flags),
  .blk_count   (blk_count),
  .pool_loaded (pool_loaded),
  .stage_empty (stage_empty),
  .stage_full  (stage_full),
  .blk_done    (blk_done)
);

// File: tb/tb_rxblk_fifo.sv
`timescale 1ns/1ps
module tb_rxblk_fifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_transp, wr_valid, wr_sof, wr_eof, rd_en, rx_ack, isr_rd, rx_reset;
  logic [7:0] wr_data, rd_data;
  logic [2:0] int_mask, isr_flags;
  logic [4:0] blk_count;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q [0:63];
  int exp_n;

  always #10 clk = ~clk;

  rxblk_fifo dut (
    .clk(clk), .rst_n(rst_n), .mode_transp(mode_transp),
    .wr_valid(wr_valid), .wr_sof(wr_sof), .wr_eof(wr_eof), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rx_ack(rx_ack), .isr_rd(isr_rd),
    .rx_reset(rx_reset), .int_mask(int_mask), .isr_flags(isr_flags),
    .blk_count(blk_count), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d, logic s, logic e);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_sof = s; wr_eof = e;
    @(negedge clk);
    wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
  endtask

  task automatic pulse_isr();
    @(negedge clk); isr_rd = 1'b1;
    @(negedge clk); isr_rd = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rx_reset = 1'b1;
    @(negedge clk); rx_reset = 1'b0;
  endtask

  // framed send: n data bytes then status; records expected bytes
  task automatic send_frame(int n, logic [7:0] base, logic [7:0] stat);
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      wr(base + 8'(i), i == 0, 1'b0);
      exp_q[exp_n] = base + 8'(i); exp_n++;
    end
    wr(stat, n == 0, 1'b1);
    exp_q[exp_n] = stat; exp_n++;
  endtask

  task automatic read_cmp(string req, int from, int n);
    for (int i = 0; i < n; i++) begin
      check(req, rd_data, exp_q[from + i]);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
    end
  endtask

  task automatic t_reset_state();
    check("R9 reset flags", isr_flags, 3'b000);
    check("R9 reset count", blk_count, 5'd0);
    check("R10 reset irq", irq, 1'b0);
  endtask

  task automatic t_short_frame();
    send_frame(5, 8'h10, 8'hA5);
    idle(4);
    check("R1 short flags", isr_flags, 3'b010);
    check("R1 short count", blk_count, 5'd6);
    read_cmp("R3 short data", 0, 6);
    pulse_isr();
    check("R8 clear", isr_flags, 3'b000);
    pulse_ack();
  endtask

  task automatic t_long_frame();
    send_frame(40, 8'h40, 8'h5C);
    idle(4);
    check("R2 first block flags", isr_flags, 3'b001);
    check("R2 first block count", blk_count, 5'd0);
    read_cmp("R3 first block data", 0, 32);
    pulse_isr();
    idle(6);
    check("R4 held flags", isr_flags, 3'b000);
    check("R4 held count", blk_count, 5'd0);
    pulse_ack();
    idle(14);
    check("R2 tail flags", isr_flags, 3'b010);
    check("R2 tail count", blk_count, 5'd9);
    read_cmp("R3 tail data", 32, 9);
    pulse_isr();
    pulse_ack();
  endtask

  task automatic t_overflow();
    logic [7:0] a_exp [0:31];
    logic [7:0] b_exp [0:31];
    send_frame(31, 8'h80, 8'hE1);
    for (int i = 0; i < 32; i++) a_exp[i] = exp_q[i];
    idle(4);
    check("R1 exact flags", isr_flags, 3'b010);
    check("R1 exact count", blk_count, 5'd0);
    send_frame(31, 8'hA0, 8'hE2);
    for (int i = 0; i < 32; i++) b_exp[i] = exp_q[i];
    send_frame(3, 8'h20, 8'hE3);
    check("R5 overflow flag", isr_flags, 3'b110);
    int_mask = 3'b000; #1;
    check("R10 unmasked", irq, 1'b1);
    int_mask = 3'b110; #1;
    check("R10 all masked", irq, 1'b0);
    int_mask = 3'b011; #1;
    check("R10 ovf unmasked", irq, 1'b1);
    int_mask = 3'b000;
    // status read in the same cycle as another dropped frame start
    @(negedge clk);
    isr_rd = 1'b1; wr_valid = 1'b1; wr_sof = 1'b1; wr_eof = 1'b1; wr_data = 8'h77;
    @(negedge clk);
    isr_rd = 1'b0; wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
    check("R8 event kept", isr_flags, 3'b100);
    pulse_isr();
    check("R8 cleared", isr_flags, 3'b000);
    for (int i = 0; i < 32; i++) exp_q[i] = a_exp[i];
    read_cmp("R3 frame A data", 0, 32);
    pulse_ack();
    idle(40);
    check("R5 next frame flags", isr_flags, 3'b010);
    check("R5 next frame count", blk_count, 5'd0);
    for (int i = 0; i < 32; i++) exp_q[i] = b_exp[i];
    read_cmp("R5 frame B intact", 0, 32);
    pulse_isr();
    pulse_ack();
    idle(10);
    check("R5 dropped frame absent", isr_flags, 3'b000);
    send_frame(2, 8'h30, 8'hE4);
    idle(4);
    check("R5 later frame flags", isr_flags, 3'b010);
    check("R5 later frame count", blk_count, 5'd3);
    read_cmp("R5 later frame data", 0, 3);
    pulse_isr();
    pulse_ack();
  endtask

  task automatic t_transparent();
    mode_transp = 1'b1;
    for (int i = 0; i < 32; i++) begin
      exp_q[i] = 8'hC0 + 8'(i);
      wr(exp_q[i], i == 6, i == 5);
    end
    idle(4);
    check("R6 block flags", isr_flags, 3'b001);
    check("R6 block count", blk_count, 5'd0);
    read_cmp("R6 block data", 0, 32);
    pulse_isr();
    for (int i = 0; i < 32; i++) wr(8'h01 + 8'(i), 1'b0, 1'b0);
    check("R7 no loss yet", isr_flags, 3'b000);
    wr(8'hFF, 1'b0, 1'b0);
    check("R7 loss flag", isr_flags, 3'b100);
    pulse_reset();
    check("R9 flags cleared", isr_flags, 3'b000);
    check("R9 count cleared", blk_count, 5'd0);
    mode_transp = 1'b0;
    idle(4);
    check("R9 nothing left", isr_flags, 3'b000);
    send_frame(1, 8'h5A, 8'hE5);
    idle(4);
    check("R9 fresh frame flags", isr_flags, 3'b010);
    check("R9 fresh frame count", blk_count, 5'd2);
    read_cmp("R9 fresh frame data", 0, 2);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_transp = 1'b0; wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
    wr_data = 8'h00; rd_en = 1'b0; rx_ack = 1'b0; isr_rd = 1'b0; rx_reset = 1'b0;
    int_mask = 3'b000;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset_state();
    t_short_frame();
    t_long_frame();
    t_overflow();
    t_transparent();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule